// File: doc/BRIEF.md
# Page Access and Write-Policy Unit

This block stands between a contactless-ticket command decoder and a 48-page memory of 32-bit pages. For every read or write request it decides whether the access is allowed, and answers with a 4-bit code. A read that is allowed returns four consecutive page addresses and their contents. The sequence wraps back to page 0 rather than running into the secret key pages or into a read-protected region. A write that is allowed produces the merged word to store and a one-cycle commit strobe. The merge honours one-time-programmable pages, lock bits and the bits that freeze those lock bits.

A register array of 48 words stands in for the nonvolatile store. The protection settings are taken from that array: the lock bytes, the first protected page and the read-only flag. Page bytes are numbered from the least significant end, so byte 0 is bits [7:0]. The decoder supplies the protocol state on `auth_ok`: 1 means authenticated and 0 means plain active. It also flags a corrupted frame (CRC or parity) on `frame_err`.

Top module: `page_access_unit`

## Requirements
- R1: A request sampled with `req_valid` high is answered one cycle later with `rsp_valid` high and `rsp_code` equal to 0xA (accepted), 0x0 (invalid argument) or 0x1 (frame error).
- R2: Any read or write to a page address above 47 gets 0x0 and commits nothing.
- R3: Writes to pages 0 and 1 get 0x0. An accepted write to page 2 never changes its bytes 0 and 1.
- R4: Pages 3, 16, 17 and 18 are one-time programmable: an accepted write stores the old word OR the new data.
- R5: Page-2 lock bits control page 3 and pages 4..15. The lock bit for page 3 is word bit 19. The lock bits for pages 4..15 are word bits 20..31, in page order. A write to a locked page gets 0x0 and leaves the page unchanged.
- R6: Page-40 lock bits control the following pages. Bits 0..5 each lock a group of four pages, starting at 16, 20, 24, 28, 32 and 36. Bits 8, 9 and 10 lock pages 41, 42 and 43. Bit 11 locks pages 44..47. Pages 2 and 40 are never locked.
- R7: Lock bits are OR-written. Page-2 bit 16 freezes bit 19. Bit 17 freezes bits 20..25. Bit 18 freezes bits 26..31. Page-40 bit 6 freezes bits 0..2. Bit 7 freezes bits 3..5. Bits 12..15 freeze bits 8..11 one for one. A frozen bit keeps its old value. Page-40 bytes 2 and 3 are written plainly.
- R8: The first protected page comes from byte 0 of page 42. The read-only flag is bit 0 of page 43. With `auth_ok` low and the first protected page at 47 or below, addresses from that page upward reject writes with 0x0. Reads there also get 0x0 unless the read-only flag is 1. With `auth_ok` high no region applies.
- R9: An accepted read gives the start page in `rd_pages[5:0]`, followed by three more pages in 6-bit slices. `rd_data` carries each page's word, with slice i in bits [32i+31:32i]. Read addresses 44 and above get 0x0.
- R10: A read burst steps to page 0 instead of reaching page 44. With `auth_ok` low and the read-only flag 0, it also steps to page 0 instead of reaching the first protected page.
- R11: A request with `frame_err` high gets 0x1 and commits nothing.
- R12: An accepted write raises `commit_valid` for one cycle with the page and merged word. The array holds that word from then on.
- R13: After reset: page 0 = ID_P0, page 1 = ID_P1, page 2 = ID_P2 in its low half, page 42 = 48 (no region), all other pages 0, and no response or commit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Page address from the command |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| auth_ok | input | 1 | 1 authenticated, 0 active |
| frame_err | input | 1 | CRC or parity error on the command frame |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 4 | 0xA, 0x0 or 0x1 |
| rd_pages | output | 24 | Four 6-bit page addresses of the burst |
| rd_data | output | 128 | Four page words of the burst |
| commit_valid | output | 1 | Write commit strobe |
| commit_addr | output | 6 | Page being written |
| commit_data | output | 32 | Merged word being written |

## Verification
The assertions assume that every request lasts exactly one cycle. They also assume that `auth_ok` and `frame_err` are only meaningful while `req_valid` is high, and that a response is matched to the request of the previous cycle. The bench raises `req_valid` for a single cycle and drops it for one idle cycle before sampling, so responses never overlap. Protection settings are changed only through the block's own write path, with `auth_ok` high whenever the settings pages fall inside the region.

// File: rtl/page_access_unit.sv
module page_access_unit #(
  parameter int NPAGES = 48,
  parameter int KEY_BASE = 44,
  parameter int LOCK_PAGE = 40,
  parameter int AUTH0_PAGE = 42,
  parameter int AUTH1_PAGE = 43,
  parameter int BURST = 4,
  parameter logic [31:0] ID_P0 = 32'h88A1_B2C3,
  parameter logic [31:0] ID_P1 = 32'h1122_3344,
  parameter logic [15:0] ID_P2 = 16'h0048,
  localparam int PW = $clog2(NPAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [7:0]            req_addr,
  input  logic [31:0]           req_wdata,
  input  logic                  auth_ok,
  input  logic                  frame_err,
  output logic                  rsp_valid,
  output logic [3:0]            rsp_code,
  output logic [BURST*PW-1:0]   rd_pages,
  output logic [BURST*32-1:0]   rd_data,
  output logic                  commit_valid,
  output logic [PW-1:0]         commit_addr,
  output logic [31:0]           commit_data
);

  logic [31:0] mem [NPAGES];

  wire [31:0]   lk_a  = mem[2];
  wire [31:0]   lk_b  = mem[LOCK_PAGE];
  wire [7:0]    bound = mem[AUTH0_PAGE][7:0];
  wire          ro    = mem[AUTH1_PAGE][0];
  wire [PW-1:0] pg    = req_addr[PW-1:0];

  wire in_range = req_addr < 8'(NPAGES);
  wire guard_on = !auth_ok && bound < 8'(NPAGES);
  wire in_guard = guard_on && req_addr >= bound;

  logic [63:0] lock_vec;
  always_comb begin
    lock_vec = '0;
    lock_vec[3] = lk_a[19];
    lock_vec[15:4] = lk_a[31:20];
    for (int g = 0; g < 6; g++) lock_vec[16 + 4*g +: 4] = {4{lk_b[g]}};
    lock_vec[43:41] = lk_b[10:8];
    lock_vec[47:44] = {4{lk_b[11]}};
  end
  wire pg_locked = lock_vec[req_addr[5:0]];

  wire [31:0] frz_a = {{6{lk_a[18]}}, {6{lk_a[17]}}, lk_a[16], 3'b000, 16'h0000};
  wire [15:0] frz_b = {4'b0000, lk_b[15:12], 2'b00, {3{lk_b[7]}}, {3{lk_b[6]}}};

  logic [31:0] merged;
  always_comb begin
    if (pg == PW'(2))
      merged = {lk_a[31:16] | (req_wdata[31:16] & ~frz_a[31:16]), lk_a[15:0]};
    else if (pg == PW'(LOCK_PAGE))
      merged = {req_wdata[31:16], lk_b[15:0] | (req_wdata[15:0] & ~frz_b)};
    else if (pg == PW'(3) || pg == PW'(16) || pg == PW'(17) || pg == PW'(18))
      merged = mem[pg] | req_wdata;
    else
      merged = req_wdata;
  end

  wire wr_bad = !in_range || pg < PW'(2) || pg_locked || in_guard;
  wire rd_bad = !in_range || req_addr >= 8'(KEY_BASE) || (in_guard && !ro);
  wire do_commit = req_valid && !frame_err && req_write && !wr_bad;
  wire do_read   = req_valid && !frame_err && !req_write && !rd_bad;

  wire [PW-1:0] wrap_at = (guard_on && !ro && bound < 8'(KEY_BASE)) ? bound[PW-1:0] : PW'(KEY_BASE);

  logic [BURST-1:0][PW-1:0] bp;
  always_comb begin
    bp[0] = pg;
    for (int i = 1; i < BURST; i++)
      bp[i] = (bp[i-1] + 1'b1 == wrap_at) ? '0 : bp[i-1] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAGES; p++)
        mem[p] <= (p == 0) ? ID_P0 :
                  (p == 1) ? ID_P1 :
                  (p == 2) ? {16'h0000, ID_P2} :
                  (p == AUTH0_PAGE) ? 32'(NPAGES) : 32'h0;
    end else if (do_commit) begin
      mem[pg] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= 4'h0;
      rd_pages     <= '0;
      rd_data      <= '0;
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
    end else begin
      rsp_valid    <= req_valid;
      commit_valid <= do_commit;
      if (req_valid)
        rsp_code <= frame_err ? 4'h1 : (req_write ? wr_bad : rd_bad) ? 4'h0 : 4'hA;
      if (do_commit) begin
        commit_addr <= pg;
        commit_data <= merged;
      end
      if (do_read)
        for (int i = 0; i < BURST; i++) begin
          rd_pages[i*PW +: PW] <= bp[i];
          rd_data[i*32 +: 32]  <= mem[bp[i]];
        end
    end
  end

endmodule

module page_access_unit_chk #(
  parameter int PW = 6,
  parameter int BURST = 4,
  parameter int KEY_BASE = 44,
  parameter int NPAGES = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [7:0]          req_addr,
  input logic                frame_err,
  input logic                rsp_valid,
  input logic [3:0]          rsp_code,
  input logic [BURST*PW-1:0] rd_pages,
  input logic                commit_valid,
  input logic [PW-1:0]       commit_addr
);

  logic last_rd;
  logic [PW-1:0] last_pg;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_rd <= 1'b0;
      last_pg <= '0;
    end else begin
      last_rd <= req_valid && !req_write;
      last_pg <= req_addr[PW-1:0];
    end

  wire rd_ack = rsp_valid && rsp_code == 4'hA && last_rd;

  a_r1_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && (rsp_code == 4'hA || rsp_code == 4'h0 || rsp_code == 4'h1));

  a_r11_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && frame_err |=> rsp_code == 4'h1 && !commit_valid);

  a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !frame_err && req_addr >= 8'(NPAGES) |=> rsp_code == 4'h0 && !commit_valid);

  a_r3_id_pages: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !frame_err && req_addr < 8'd2 |=> rsp_code == 4'h0 && !commit_valid);

  a_r12_commit_ack: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> rsp_valid && rsp_code == 4'hA && commit_addr >= PW'(2));

  a_r9_start_page: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> rd_pages[PW-1:0] == last_pg);

  for (genvar i = 0; i < BURST; i++) begin : g_pg
    a_r9_no_key: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> rd_pages[i*PW +: PW] < PW'(KEY_BASE));
    if (i > 0) begin : g_step
      a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (rd_pages[i*PW +: PW] == rd_pages[(i-1)*PW +: PW] + 1'b1) ||
                   (rd_pages[i*PW +: PW] == '0));
    end
  end

endmodule

bind page_access_unit page_access_unit_chk #(
  .PW(PW), .BURST(BURST), .KEY_BASE(KEY_BASE), .NPAGES(NPAGES)
) u_chk (.*);

// File: tb/tb_page_access_unit.sv
module tb_page_access_unit;
  localparam logic [31:0] P0 = 32'h04C0_FFEE;
  localparam logic [31:0] P1 = 32'h5566_7788;
  localparam logic [15:0] P2 = 16'h0099;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, auth_ok = 0, frame_err = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, commit_valid;
  logic [3:0] rsp_code;
  logic [23:0] rd_pages;
  logic [127:0] rd_data;
  logic [5:0] commit_addr;
  logic [31:0] commit_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m [48];

  always #5 clk = ~clk;

  page_access_unit #(.ID_P0(P0), .ID_P1(P1), .ID_P2(P2)) dut (.*);

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic bit locked(int p);
    if (p == 3) return m[2][19];
    if (p >= 4 && p <= 15) return m[2][16 + p];
    if (p >= 16 && p <= 39) return m[40][(p - 16) / 4];
    if (p >= 41 && p <= 43) return m[40][p - 33];
    if (p >= 44 && p <= 47) return m[40][11];
    return 1'b0;
  endfunction

  function automatic logic [31:0] merge(int p, logic [31:0] d);
    logic [31:0] r = m[p];
    if (p == 2) begin
      for (int k = 16; k < 32; k++) begin
        bit fz = (k == 19 && m[2][16]) || (k >= 20 && k <= 25 && m[2][17]) || (k >= 26 && m[2][18]);
        if (!fz) r[k] = r[k] | d[k];
      end
    end else if (p == 40) begin
      r[31:16] = d[31:16];
      for (int k = 0; k < 16; k++) begin
        bit fz = (k <= 2 && m[40][6]) || (k >= 3 && k <= 5 && m[40][7]) ||
                 (k >= 8 && k <= 11 && m[40][k + 4]);
        if (!fz) r[k] = r[k] | d[k];
      end
    end else if (p == 3 || (p >= 16 && p <= 18)) r = r | d;
    else r = d;
    return r;
  endfunction

  task automatic req(bit wr, int a, logic [31:0] d, bit au, bit fe, string rq);
    logic [3:0] ec;
    int b = int'(m[42][7:0]);
    bit guard = !au && b < 48 && a >= b;
    int lim = (!au && !m[43][0] && b < 44) ? b : 44;
    if (fe) ec = 4'h1;
    else if (wr) ec = (a >= 48 || a < 2 || locked(a) || guard) ? 4'h0 : 4'hA;
    else ec = (a >= 44 || (guard && !m[43][0])) ? 4'h0 : 4'hA;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a[7:0]; req_wdata = d; auth_ok = au; frame_err = fe;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_code == ec, rq, $sformatf("code a=%0d", a), {rsp_valid, rsp_code}, {1'b1, ec});
    if (wr && ec == 4'hA) begin
      logic [31:0] nv = merge(a, d);
      chk(commit_valid && commit_addr == a[5:0] && commit_data == nv, "R12",
          $sformatf("commit a=%0d", a), {commit_valid, commit_addr, commit_data}, {1'b1, a[5:0], nv});
      m[a] = nv;
    end else begin
      chk(!commit_valid, rq, $sformatf("no commit a=%0d", a), commit_valid, 0);
    end
    if (!wr && ec == 4'hA) begin
      int p = a;
      for (int i = 0; i < 4; i++) begin
        chk(rd_pages[i*6 +: 6] == p[5:0] && rd_data[i*32 +: 32] == m[p], "R10",
            $sformatf("burst a=%0d slot %0d", a, i), {rd_pages[i*6 +: 6], rd_data[i*32 +: 32]},
            {p[5:0], m[p]});
        p = (p + 1 == lim) ? 0 : p + 1;
      end
    end
  endtask

  task automatic read_sweep(bit au, string rq);
    for (int a = 0; a < 64; a++) req(1'b0, a, 32'h0, au, 1'b0, rq);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 48; p++) m[p] = 32'h0;
    m[0] = P0; m[1] = P1; m[2] = {16'h0, P2}; m[42] = 32'd48;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !commit_valid, "R13", "idle after reset", {rsp_valid, commit_valid}, 0);
    rst_n = 1;
    read_sweep(1'b1, "R13");
    for (int a = 0; a < 64; a++)
      if (a != 2 && a != 40 && a != 42 && a != 43)
        req(1'b1, a, {a[7:0], ~a[7:0], 8'h5A ^ a[7:0], 8'hC3}, 1'b1, 1'b0, "R2");
    foreach (m[p]) if (p == 3 || (p >= 16 && p <= 18))
      req(1'b1, p, 32'h0F0F_00F0, 1'b1, 1'b0, "R4");
    read_sweep(1'b1, "R9");
    req(1'b1, 5, 32'hDEAD_BEEF, 1'b1, 1'b1, "R11");
    req(1'b0, 5, 32'h0, 1'b1, 1'b1, "R11");
    req(1'b0, 4, 32'h0, 1'b1, 1'b0, "R11");
    req(1'b1, 2, 32'h0008_FFFF, 1'b1, 1'b0, "R3");
    req(1'b1, 3, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");
    req(1'b1, 2, 32'h0004_0000, 1'b1, 1'b0, "R7");
    req(1'b1, 2, 32'h0420_0000, 1'b1, 1'b0, "R7");
    req(1'b1, 10, 32'h1234_5678, 1'b1, 1'b0, "R7");
    req(1'b1, 5, 32'h1234_5678, 1'b1, 1'b0, "R5");
    req(1'b1, 40, 32'hABCD_0001, 1'b1, 1'b0, "R6");
    req(1'b1, 17, 32'h1, 1'b1, 1'b0, "R6");
    req(1'b1, 40, 32'h0000_0040, 1'b1, 1'b0, "R7");
    req(1'b1, 40, 32'h0000_0002, 1'b1, 1'b0, "R7");
    req(1'b1, 21, 32'h7777_7777, 1'b1, 1'b0, "R7");
    req(1'b1, 40, 32'h0000_0900, 1'b1, 1'b0, "R6");
    req(1'b1, 41, 32'h1, 1'b1, 1'b0, "R6");
    req(1'b1, 45, 32'h1, 1'b1, 1'b0, "R6");
    req(1'b1, 44, 32'h1, 1'b1, 1'b0, "R6");
    read_sweep(1'b1, "R9");
    foreach (m[b]) if (b == 2 || b == 32 || b == 43 || b == 46) begin
      req(1'b1, 42, 32'(b), 1'b1, 1'b0, "R8");
      req(1'b1, 43, 32'h0, 1'b1, 1'b0, "R8");
      read_sweep(1'b0, "R8");
      for (int a = 0; a < 48; a += 7) req(1'b1, a, 32'h3000_0000 + a, 1'b0, 1'b0, "R8");
      req(1'b1, 43, 32'h1, 1'b1, 1'b0, "R8");
      read_sweep(1'b0, "R10");
      read_sweep(1'b1, "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule